// File: doc/BRIEF.md
# Quarter-Wave Sine Amplitude Lookup

This block turns a phase word into a signed sine amplitude. Only the rising first quarter of a sine period is stored. The other three quarters come from that quarter by symmetry: the two top phase bits name the quadrant, and the remaining bits give the position inside it. Depending on the quadrant, that position either addresses the stored quarter as it is or is bit-inverted first. The quadrant also sets the sign of the result. Storage is therefore a quarter of what a full-period table would need.

The phase normally comes from an upstream accumulator. A test-select input can switch the lookup to a separate externally driven phase, so the conversion can be exercised on its own. A valid flag travels with each sample, and every sample appears exactly two clock cycles after it is accepted. The stored quarter is computed while the design is elaborated, so no data file is needed.

Top module: `qsine_lookup`

## Requirements
- R1: The phase word is split into a quadrant code in `phase[9:8]` and an offset in `phase[7:0]`.
- R2: In quadrants 2'b00 and 2'b10 the output magnitude `amp[7:0]` equals round(255·sin(π/2·(offset+0.5)/256)).
- R3: In quadrants 2'b01 and 2'b11 the magnitude is the table entry at address `~offset`, which is the R2 value for offset 255−offset.
- R4: The sign bit `amp[8]` is 0 for quadrants 2'b00 and 2'b01 and 1 for quadrants 2'b10 and 2'b11 (sign-magnitude output).
- R5: Every magnitude lies in 1..255. Table address 255 gives 255 and address 0 gives 1.
- R6: `out_valid` equals `in_valid` from two clock cycles earlier, and the amplitude for a phase accepted at one edge is presented after the second following edge.
- R7: With `test_en`=1 the phase is taken from `test_phase` and `acc_phase` has no effect. With `test_en`=0 the phase is taken from `acc_phase`.
- R8: While `rst_n` is low, `out_valid` is 0 and `amp` is 0.
- R9: A cycle with `in_valid`=0 does not change the data path, so `amp` keeps its last value while `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Selected phase is meaningful this cycle |
| test_en | input | 1 | 1 selects `test_phase`, 0 selects `acc_phase` |
| acc_phase | input | 10 | Phase from the accumulator |
| test_phase | input | 10 | Externally driven phase for isolated testing |
| out_valid | output | 1 | `amp` carries a new sample |
| amp | output | 9 | Sign (bit 8) and magnitude (bits 7:0) |

## Verification
Every amplitude and valid result is due two rising edges after the edge that accepts its phase. The bench drives inputs on falling edges and keeps a two-deep queue of expected samples. At each falling edge it first compares the outputs with the entry queued two drives earlier, and only then applies new inputs. When that queued entry is not valid, the bench instead expects `out_valid` low and `amp` equal to the most recent valid result.

// File: rtl/qsine_pkg.sv
package qsine_pkg;

    localparam int unsigned PHASE_W_DEF = 10;
    localparam int unsigned AMP_W_DEF   = 9;
    localparam real         HALF_PI     = 1.5707963267948966;

    // Quadrant codes taken from the two top phase bits
    typedef enum logic [1:0] {
        QUAD_RISE    = 2'b00,
        QUAD_FALL    = 2'b01,
        QUAD_DIP     = 2'b10,
        QUAD_RECOVER = 2'b11
    } quad_e;

endpackage

// File: rtl/qsine_fold.sv
// Stage 1: chooses the phase source, folds the offset into a quarter-table address
// and derives the sign from the quadrant.
module qsine_fold #(
    parameter  int unsigned PHASE_W = 10,
    localparam int unsigned OFF_W   = PHASE_W - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_vld,
    input  logic               test_en,
    input  logic [PHASE_W-1:0] acc_phase,
    input  logic [PHASE_W-1:0] test_phase,
    output logic               out_vld,
    output logic [OFF_W-1:0]   out_addr,
    output logic               out_neg
);
    import qsine_pkg::*;

    typedef struct packed {
        logic             vld;
        logic [OFF_W-1:0] addr;
        logic             neg;
    } fold_t;

    fold_t              fold_d, fold_q;
    logic [PHASE_W-1:0] phase_sel;
    quad_e              quad;
    logic [OFF_W-1:0]   offset;

    always_comb begin
        phase_sel = test_en ? test_phase : acc_phase;
        quad      = quad_e'(phase_sel[PHASE_W-1 -: 2]);
        offset    = phase_sel[OFF_W-1:0];

        fold_d     = fold_q;
        fold_d.vld = in_vld;
        if (in_vld) begin
            unique case (quad)
                QUAD_RISE:    begin fold_d.addr = offset;  fold_d.neg = 1'b0; end
                QUAD_FALL:    begin fold_d.addr = ~offset; fold_d.neg = 1'b0; end
                QUAD_DIP:     begin fold_d.addr = offset;  fold_d.neg = 1'b1; end
                QUAD_RECOVER: begin fold_d.addr = ~offset; fold_d.neg = 1'b1; end
                default:      begin fold_d.addr = offset;  fold_d.neg = 1'b0; end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fold_q <= '0;
        else        fold_q <= fold_d;
    end

    assign out_vld  = fold_q.vld;
    assign out_addr = fold_q.addr;
    assign out_neg  = fold_q.neg;

endmodule

// File: rtl/qsine_rom.sv
// Stage 2: registered read of the quarter-period magnitude table.
module qsine_rom #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned MAG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_neg,
    output logic              out_vld,
    output logic [MAG_W-1:0]  out_mag,
    output logic              out_neg
);
    import qsine_pkg::*;

    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam int unsigned PEAK  = (1 << MAG_W) - 1;

    // Sample at the middle of each step: round(PEAK * sin(pi/2 * (i + 0.5) / DEPTH))
    function automatic logic [DEPTH*MAG_W-1:0] build_quarter();
        logic [DEPTH*MAG_W-1:0] t;
        real                    ang;
        int                     v;
        t = '0;
        for (int i = 0; i < DEPTH; i++) begin
            ang = HALF_PI * (real'(i) + 0.5) / real'(DEPTH);
            v   = $rtoi(real'(PEAK) * $sin(ang) + 0.5);
            t[i*MAG_W +: MAG_W] = MAG_W'(v);
        end
        return t;
    endfunction

    localparam logic [DEPTH*MAG_W-1:0] QUARTER = build_quarter();

    typedef struct packed {
        logic             vld;
        logic [MAG_W-1:0] mag;
        logic             neg;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d     = rd_q;
        rd_d.vld = in_vld;
        if (in_vld) begin
            rd_d.mag = QUARTER[int'(in_addr)*MAG_W +: MAG_W];
            rd_d.neg = in_neg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign out_vld = rd_q.vld;
    assign out_mag = rd_q.mag;
    assign out_neg = rd_q.neg;

endmodule

// File: rtl/qsine_lookup.sv
module qsine_lookup #(
    parameter  int unsigned PHASE_W = qsine_pkg::PHASE_W_DEF,
    parameter  int unsigned AMP_W   = qsine_pkg::AMP_W_DEF,
    localparam int unsigned OFF_W   = PHASE_W - 2,
    localparam int unsigned MAG_W   = AMP_W - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               test_en,
    input  logic [PHASE_W-1:0] acc_phase,
    input  logic [PHASE_W-1:0] test_phase,
    output logic               out_valid,
    output logic [AMP_W-1:0]   amp
);
    logic             s1_vld;
    logic [OFF_W-1:0] s1_addr;
    logic             s1_neg;
    logic [MAG_W-1:0] s2_mag;
    logic             s2_neg;

    qsine_fold #(.PHASE_W(PHASE_W)) u_fold (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_vld     (in_valid),
        .test_en    (test_en),
        .acc_phase  (acc_phase),
        .test_phase (test_phase),
        .out_vld    (s1_vld),
        .out_addr   (s1_addr),
        .out_neg    (s1_neg)
    );

    qsine_rom #(.ADDR_W(OFF_W), .MAG_W(MAG_W)) u_rom (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (s1_vld),
        .in_addr (s1_addr),
        .in_neg  (s1_neg),
        .out_vld (out_valid),
        .out_mag (s2_mag),
        .out_neg (s2_neg)
    );

    assign amp = {s2_neg, s2_mag};

endmodule

// File: rtl/qsine_checker.sv
module qsine_checker #(
    parameter int unsigned PHASE_W = 10,
    parameter int unsigned AMP_W   = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               test_en,
    input logic [PHASE_W-1:0] acc_phase,
    input logic [PHASE_W-1:0] test_phase,
    input logic               out_valid,
    input logic [AMP_W-1:0]   amp
);
    localparam int unsigned MAG_W = AMP_W - 1;
    localparam int unsigned OFF_W = PHASE_W - 2;

    logic [1:0]         warm_q;
    logic [PHASE_W-1:0] sel_phase;

    assign sel_phase = test_en ? test_phase : acc_phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              warm_q <= 2'd0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    p_reset_clear_r8: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && amp == '0));

    p_valid_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    p_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2 && out_valid) |-> (amp[AMP_W-1] == $past(sel_phase[PHASE_W-1], 2)));

    p_mag_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (amp[MAG_W-1:0] != '0));

    p_peak_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2 && out_valid
         && $past(sel_phase[PHASE_W-1 -: 2], 2) == 2'b00
         && $past(sel_phase[OFF_W-1:0], 2) == {OFF_W{1'b1}})
        |-> (amp[MAG_W-1:0] == {MAG_W{1'b1}}));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(amp));

endmodule

bind qsine_lookup qsine_checker #(.PHASE_W(PHASE_W), .AMP_W(AMP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .test_en    (test_en),
    .acc_phase  (acc_phase),
    .test_phase (test_phase),
    .out_valid  (out_valid),
    .amp        (amp)
);

// File: tb/qsine_lookup_bench.sv
`timescale 1ns/1ps
module qsine_lookup_bench;
    localparam int PW = 10;
    localparam int AW = 9;
    localparam int MW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic          test_en;
    logic [PW-1:0] acc_phase;
    logic [PW-1:0] test_phase;
    logic          out_valid;
    logic [AW-1:0] amp;

    always #4 clk = ~clk;

    qsine_lookup u_qsine_lookup (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .test_en    (test_en),
        .acc_phase  (acc_phase),
        .test_phase (test_phase),
        .out_valid  (out_valid),
        .amp        (amp)
    );

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 0;
    logic          d1_v, d2_v;
    logic [AW-1:0] d1_a, d2_a, hold;
    string         d1_t, d2_t;

    // Expected sign-magnitude amplitude from R1..R4
    function automatic logic [AW-1:0] model(input logic [PW-1:0] ph);
        logic [1:0] q;
        logic [7:0] off, a;
        int         m;
        q   = ph[9:8];
        off = ph[7:0];
        a   = q[0] ? ~off : off;
        m   = $rtoi(255.0 * $sin(1.5707963267948966 * (real'(a) + 0.5) / 256.0) + 0.5);
        return {q[1], 8'(m)};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input bit v, input bit te, input logic [PW-1:0] acc,
                        input logic [PW-1:0] tp, input string tag);
        logic [PW-1:0] ph;
        @(negedge clk);
        if (d2_v) begin
            check("R6", int'(out_valid), 1);
            check(d2_t, int'(amp[MW-1:0]), int'(d2_a[MW-1:0]));
            check("R4", int'(amp[AW-1]), int'(d2_a[AW-1]));
            hold = d2_a;
        end else begin
            check("R6", int'(out_valid), 0);
            check("R9", int'(amp), int'(hold));
        end
        d2_v = d1_v; d2_a = d1_a; d2_t = d1_t;
        ph   = te ? tp : acc;
        d1_v = v;
        d1_a = model(ph);
        d1_t = (tag != "") ? tag : (ph[8] ? "R3" : "R2");
        in_valid   = v;
        test_en    = te;
        acc_phase  = acc;
        test_phase = tp;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; in_valid = 1'b1; test_en = 1'b0;
        acc_phase = 10'h0FF; test_phase = '0;
        d1_v = 0; d2_v = 0; d1_a = '0; d2_a = '0; hold = '0; d1_t = ""; d2_t = "";
        repeat (3) @(negedge clk);
        check("R8", int'(out_valid), 0);
        check("R8", int'(amp), 0);
        in_valid = 1'b0;
        rst_n = 1'b1;

        // Directed corners
        step(1, 0, 10'h0FF, 10'h000, "R5");   // peak of quadrant 00
        step(1, 0, 10'h000, 10'h000, "R5");   // smallest magnitude
        step(1, 0, 10'h100, 10'h000, "R3");   // folded to address 255
        step(1, 0, 10'h3FF, 10'h000, "R3");   // folded to address 0, negative
        step(1, 0, 10'h2FF, 10'h000, "R1");   // quadrant 10 top offset
        step(1, 0, 10'h255, 10'h000, "R1");
        step(1, 1, 10'h000, 10'h0FF, "R7");   // test phase wins
        step(1, 1, 10'h3FF, 10'h180, "R7");
        step(1, 0, 10'h0FF, 10'h000, "R7");   // accumulator phase wins
        step(0, 1, 10'h123, 10'h321, "R9");
        step(0, 0, 10'h2AA, 10'h155, "R9");
        step(0, 0, 10'h000, 10'h3FF, "R9");
        step(1, 0, 10'h1C0, 10'h000, "");

        // Constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 4) != 0, $urandom % 2, PW'($urandom), PW'($urandom), "");
        end

        repeat (3) step(0, 0, '0, '0, "R9");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R6 actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule